// File: doc/BRIEF.md
# Grouped Configuration Commit Controller

This block coordinates when a bank of PWM channels switches over to newly written timing settings. Software stages new values in each channel beforehand. It then places channels into groups: every group holds a channel mask and a flag that asks for counter restart. When software sets a group's start bit, the block emits a one-cycle commit pulse on every channel in that group's mask. All of those pulses occur in the same clock cycle. The channel datapaths use the pulse to copy their staged settings into their active settings.

If the group's restart flag is set, the block also sends a clear pulse in that same cycle, so each selected channel's period counter starts again from zero. A joint start register lets software start several groups in one write. When more than one starting group selects a channel, that channel still gets a single commit pulse. It gets a clear pulse if any of those groups asks for one.

Register access uses a plain write port and a combinational read port. Group `g` occupies a 16-byte window at byte address `g*0x10`.

Top module: `grp_commit`

## Requirements
- R1: After reset, every channel mask reads 0, every restart flag reads 0, and the commit and clear outputs are 0.
- R2: A write to group offset 0x0 stores the low NUM_CH bits of the data as that group's channel mask (bit n selects channel n). Reading offset 0x0 returns the mask zero-extended, and data bits at or above NUM_CH are dropped.
- R3: A write to group offset 0x4 stores data bit 0 as the group's restart flag. Reading offset 0x4 returns the flag in bit 0.
- R4: A write of data bit 0 = 1 to group offset 0x8 drives commitPulse equal to that group's mask in the cycle after the write edge, for exactly one cycle. Starts on consecutive cycles give pulses on consecutive cycles.
- R5: The start bit clears itself. Offsets 0x8 and 0xC always read as 0.
- R6: clearPulse equals the started group's mask when its restart flag is 1, and is 0 when the flag is 0. A clear pulse always lies inside the commit pulse of the same cycle.
- R7: A write to byte address 0x0C starts every group g whose data bit g is 1, all in the same cycle. commitPulse is the OR of the started masks. clearPulse is the OR of the masks of the started groups whose restart flag is 1.
- R8: These writes produce no pulse and change no readable state: a start write with data bit 0 = 0, and any write to a group index at or above NUM_GROUPS.
- R9: Starting a group whose mask is 0 produces no commit and no clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W | Write byte address |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read byte address |
| rdData | output | 32 | Read data, combinational |
| commitPulse | output | NUM_CH | Per-channel load strobe |
| clearPulse | output | NUM_CH | Per-channel counter clear strobe |

## Verification
The bench builds the block with NUM_GROUPS = 3 and NUM_CH = 10, not the defaults of 4 and 16. With a 10-bit mask, data bits above the channel count are observably dropped. With only three groups, the fourth group window at 0x30 is unmapped, so the bench can show that writes there are ignored. Three groups are also enough for a joint start in which two masks overlap and only one of the two asks for a restart.

// File: rtl/grp_commit_pkg.sv
package grp_commit_pkg;
  localparam int MAX_GROUPS = 16;
  localparam int DATA_W = 32;

  // Decoded write strobes from control to datapath
  typedef struct packed {
    logic [MAX_GROUPS-1:0] selWe;
    logic [MAX_GROUPS-1:0] clrWe;
    logic [MAX_GROUPS-1:0] startReq;
    logic [DATA_W-1:0]     wdata;
  } cmtStrobe_t;
endpackage

// File: rtl/grp_commit_ctrl.sv
module grp_commit_ctrl
  import grp_commit_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output cmtStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] JOINT_ADDR = ADDR_W'(12);

  always_comb begin
    strb = '0;
    strb.wdata = wrData;
    if (wrEn) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (wrAddr[ADDR_W-1:4] == IDX_W'(g)) begin
          unique case (wrAddr[3:0])
            4'h0: strb.selWe[g] = 1'b1;
            4'h4: strb.clrWe[g] = 1'b1;
            4'h8: strb.startReq[g] = wrData[0];
            default: ;
          endcase
        end
      end
      // joint start: one bit per group
      if (wrAddr == JOINT_ADDR) begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          strb.startReq[g] = strb.startReq[g] | wrData[g];
        end
      end
    end
  end
endmodule

// File: rtl/grp_commit_dp.sv
module grp_commit_dp
  import grp_commit_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cmtStrobe_t        strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] commitPulse,
  output logic [NUM_CH-1:0] clearPulse
);
  localparam int IDX_W = ADDR_W - 4;

  logic [NUM_CH-1:0] selReg [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] clrReg;
  logic [NUM_CH-1:0] nextCommit, nextClear;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) begin
        selReg[g] <= '0;
        clrReg[g] <= 1'b0;
      end else begin
        if (strb.selWe[g]) selReg[g] <= strb.wdata[NUM_CH-1:0];
        if (strb.clrWe[g]) clrReg[g] <= strb.wdata[0];
      end
    end
  end

  // merge all groups starting this cycle
  always_comb begin
    nextCommit = '0;
    nextClear = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (strb.startReq[g]) begin
        nextCommit = nextCommit | selReg[g];
        if (clrReg[g]) nextClear = nextClear | selReg[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commitPulse <= '0;
      clearPulse <= '0;
    end else begin
      commitPulse <= nextCommit;
      clearPulse <= nextClear;
    end
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (rdAddr[ADDR_W-1:4] == IDX_W'(g)) begin
        if (rdAddr[3:0] == 4'h0) rdData[NUM_CH-1:0] = selReg[g];
        if (rdAddr[3:0] == 4'h4) rdData[0] = clrReg[g];
      end
    end
  end
endmodule

// File: rtl/grp_commit.sv
module grp_commit
  import grp_commit_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] commitPulse,
  output logic [NUM_CH-1:0] clearPulse
);
  cmtStrobe_t strb;

  grp_commit_ctrl #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  grp_commit_dp #(.NUM_GROUPS(NUM_GROUPS), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .rdAddr(rdAddr), .rdData(rdData),
    .commitPulse(commitPulse), .clearPulse(clearPulse)
  );
endmodule

// File: rtl/grp_commit_chk.sv
module grp_commit_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0]       rdData,
  input logic [NUM_CH-1:0] commitPulse,
  input logic [NUM_CH-1:0] clearPulse
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (commitPulse == '0 && clearPulse == '0));

  p_pulse_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    (|commitPulse) |-> $past(wrEn));

  p_start_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rdAddr[3:0] == 4'h8 || rdAddr[3:0] == 4'hC) |-> rdData == '0);

  p_clear_inside_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (clearPulse & ~commitPulse) == '0);

  p_other_writes_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn && wrAddr[3:0] != 4'h8 && wrAddr[3:0] != 4'hC) |-> commitPulse == '0);
endmodule

bind grp_commit grp_commit_chk #(.NUM_GROUPS(NUM_GROUPS), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddr(rdAddr), .rdData(rdData), .commitPulse(commitPulse), .clearPulse(clearPulse)
);

// File: tb/grp_commit_tb.sv
module grp_commit_tb;
  localparam int NG = 3;
  localparam int NC = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [NC-1:0] commitPulse, clearPulse;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  grp_commit #(.NUM_GROUPS(NG), .NUM_CH(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .commitPulse(commitPulse), .clearPulse(clearPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capture edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 commit", 32'(commitPulse), 0);
    chk("R1 clear", 32'(clearPulse), 0);
    for (int g = 0; g < NG; g++) begin
      rd(AW'(g * 16), v); chk("R1 mask", v, 0);
      rd(AW'(g * 16 + 4), v); chk("R1 flag", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_F0F3);
    rd(8'h00, v); chk("R2 mask truncated", v, 32'h0F3);
    wr(8'h14, 32'h3);
    rd(8'h14, v); chk("R3 flag", v, 32'h1);
    wr(8'h10, 32'h300);
    rd(8'h10, v); chk("R2 mask g1", v, 32'h300);
    chk("R8 no pulse on mask write", 32'(commitPulse), 0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(8'h08, 32'h1);
    chk("R4 commit g0", 32'(commitPulse), 32'h0F3);
    chk("R6 no clear g0", 32'(clearPulse), 0);
    rd(8'h08, v); chk("R5 start reads 0", v, 0);
    @(negedge clk);
    chk("R4 single cycle", 32'(commitPulse), 0);
    wr(8'h18, 32'h1);
    chk("R4 commit g1", 32'(commitPulse), 32'h300);
    chk("R6 clear g1", 32'(clearPulse), 32'h300);
    @(negedge clk);
    chk("R6 clear single", 32'(clearPulse), 0);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(8'h08, 32'h0);
    chk("R8 start with 0", 32'(commitPulse), 0);
    wr(8'h30, 32'h3FF);
    rd(8'h30, v); chk("R8 unmapped mask", v, 0);
    wr(8'h38, 32'h1);
    chk("R8 unmapped start", 32'(commitPulse), 0);
    rd(8'h00, v); chk("R8 g0 mask kept", v, 32'h0F3);
    rd(8'h10, v); chk("R8 g1 mask kept", v, 32'h300);
  endtask

  task automatic t_joint();
    logic [31:0] v;
    wr(8'h20, 32'h301);
    wr(8'h0C, 32'h6);
    chk("R7 merged commit", 32'(commitPulse), 32'h301);
    chk("R7 merged clear", 32'(clearPulse), 32'h300);
    rd(8'h0C, v); chk("R5 joint reads 0", v, 0);
    @(negedge clk);
    chk("R7 one pulse", 32'(commitPulse), 0);
  endtask

  task automatic t_back_to_back();
    wrEn = 1'b1; wrAddr = 8'h08; wrData = 32'h1;
    @(negedge clk);
    chk("R4 b2b first", 32'(commitPulse), 32'h0F3);
    wrAddr = 8'h18;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R4 b2b second", 32'(commitPulse), 32'h300);
    chk("R6 b2b clear", 32'(clearPulse), 32'h300);
    @(negedge clk);
    chk("R4 b2b end", 32'(commitPulse), 0);
  endtask

  task automatic t_empty();
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h1);
    chk("R9 empty commit", 32'(commitPulse), 0);
    chk("R9 empty clear", 32'(clearPulse), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_start();
    t_ignored();
    t_joint();
    t_back_to_back();
    t_empty();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule